// File: doc/BRIEF.md
# Command ring fetch engine

This block sits on the controller side of a host-to-codec command path. A host fills a circular ring of 256 thirty-two-bit command words in a local memory. To post a command it stores the word at slot (write pointer + 1) mod 256 and then writes that slot index into the write pointer register. The engine keeps its own read pointer, which always names the last slot it consumed. While the run bit is set and the two pointers differ, it reads the next slot from the ring memory port. It then offers the word to a serial link transmitter on a valid/ready interface. The read pointer advances only when the transmitter accepts the word.

Software reaches four 16-bit registers through a simple write strobe with a combinational read-back:

| Index | Register | Contents |
|---|---|---|
| 0 | Write pointer | Pointer in bits 7:0 |
| 1 | Read pointer | Pointer in bits 7:0, restart bit in bit 15 |
| 2 | Control | Run bit in bit 1 |
| 3 | Ring size | Size code in bits 1:0 |

Restarting the read pointer is a two-step handshake. Software writes the restart bit and sees it read back as set. It then writes zero and sees the restart bit read back as clear. Clearing the run bit is graceful: the run bit keeps reading as 1 until any fetch already under way has been delivered. While the controller is powered down, every register reads as all ones.

Top module: `cmd_ring_fetch`

## Requirements
- R1: After reset the write pointer, read pointer and control registers read 0x0000 and `cmd_valid` is low.
- R2: Each fetch reads ring slot (read pointer + 1) mod 256. The word is presented on `cmd_data`, and the read pointer advances by one, wrapping from 255 to 0, when `cmd_valid` and `cmd_ready` are both high. Entries are therefore delivered in slot order up to and including the write pointer.
- R3: No fetch starts while the read pointer equals the write pointer. A ring posted completely full (255 entries) is delivered in full and then the engine stops, with the read pointer equal to the write pointer.
- R4: Once `cmd_valid` is high it stays high with `cmd_data` unchanged until `cmd_ready` is seen. Only one command is in flight at a time.
- R5: `cmd_codec` carries bits 31:28 of the presented command word.
- R6: Fetches start only while the run bit (control register bit 1) is set. After software clears it, bit 1 reads 1 until the in-flight command is accepted, then reads 0, and no further fetch starts.
- R7: Writing the read pointer register with bit 15 set clears the read pointer and sets a restart flag. The register then reads 0x8000. A later write with bit 15 clear drops the flag, and the register then reads 0x0000.
- R8: Writes to the read pointer register with bit 15 clear leave the read pointer value unchanged.
- R9: The write pointer keeps only bits 7:0 of a write. Bits 15:8 always read as zero.
- R10: While `pwr_down` is high, every register reads 0xFFFF.
- R11: When a read pointer restart and the acceptance of a command happen in the same cycle, the restart wins and the read pointer becomes 0.
- R12: The ring size register stores bits 1:0 of a write and reads them back. The code 0x02 selects 256 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_down | input | 1 | Controller powered down; reads return all ones |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 write ptr, 1 read ptr, 2 control, 3 size |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| mem_rd_en | output | 1 | Ring memory read request |
| mem_rd_addr | output | 8 | Ring slot being read |
| mem_rd_data | input | 32 | Ring word, valid the cycle after the request |
| cmd_valid | output | 1 | Command word offered to the transmitter |
| cmd_data | output | 32 | Command word |
| cmd_codec | output | 4 | Target codec address of the command |
| cmd_ready | input | 1 | Transmitter accepts the command |

## Verification
Two functions can land in the same cycle: a software restart of the read pointer, and the transmitter accepting a command, which would advance that pointer. The bench holds a command pending with `cmd_ready` low. It then raises `cmd_ready` on the same clock edge on which it writes the restart bit. The read pointer register must read back 0x8000 rather than 0x8001, and the same slot must then be fetched again, because the pointer lies behind the write pointer once more.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_READ = 2'd1,
        FS_SEND = 2'd2
    } fetch_state_e;

    localparam logic [1:0] REG_WPTR = 2'd0;
    localparam logic [1:0] REG_RPTR = 2'd1;
    localparam logic [1:0] REG_CTRL = 2'd2;
    localparam logic [1:0] REG_SIZE = 2'd3;

    localparam int RUN_BIT = 1;

endpackage

// File: rtl/cmd_ring_regs.sv
module cmd_ring_regs
    import cmd_ring_pkg::*;
#(
    parameter int PTR_W = 8,
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_down,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [PTR_W-1:0] rp,
    input  logic             busy,
    output logic [PTR_W-1:0] wp,
    output logic             run,
    output logic             rp_clr
);

    localparam int PAD_W = REG_W - PTR_W - 1;
    localparam int RST_BIT = REG_W - 1;

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic             run;
        logic             rst_flag;
        logic [1:0]       size;
    } regs_t;

    regs_t r_q, r_d;

    logic wr_wp, wr_rp, wr_ctl, wr_size;

    always_comb begin
        wr_wp   = reg_wr && (reg_addr == REG_WPTR);
        wr_rp   = reg_wr && (reg_addr == REG_RPTR);
        wr_ctl  = reg_wr && (reg_addr == REG_CTRL);
        wr_size = reg_wr && (reg_addr == REG_SIZE);

        r_d = r_q;
        if (wr_wp)   r_d.wp       = reg_wdata[PTR_W-1:0];
        if (wr_rp)   r_d.rst_flag = reg_wdata[RST_BIT];
        if (wr_ctl)  r_d.run      = reg_wdata[RUN_BIT];
        if (wr_size) r_d.size     = reg_wdata[1:0];

        rp_clr = wr_rp && reg_wdata[RST_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (pwr_down) begin
            reg_rdata = '1;
        end else begin
            case (reg_addr)
                REG_WPTR: reg_rdata[PTR_W-1:0] = r_q.wp;
                REG_RPTR: reg_rdata = {r_q.rst_flag, {PAD_W{1'b0}}, rp};
                REG_CTRL: reg_rdata[RUN_BIT] = r_q.run | busy;
                default:  reg_rdata[1:0] = r_q.size;
            endcase
        end
    end

    assign wp  = r_q.wp;
    assign run = r_q.run;

    AST_WP_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_down && reg_addr == REG_WPTR) |-> (reg_rdata[REG_W-1:PTR_W] == '0)); // R9

    AST_STOP_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_down && reg_addr == REG_CTRL && busy) |-> reg_rdata[RUN_BIT]); // R6

endmodule

// File: rtl/cmd_ring_fetcher.sv
module cmd_ring_fetcher
    import cmd_ring_pkg::*;
#(
    parameter int PTR_W   = 8,
    parameter int DATA_W  = 32,
    parameter int CODEC_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [PTR_W-1:0]   wp,
    input  logic               rp_clr,
    output logic [PTR_W-1:0]   rp,
    output logic               busy,
    output logic               mem_rd_en,
    output logic [PTR_W-1:0]   mem_rd_addr,
    input  logic [DATA_W-1:0]  mem_rd_data,
    output logic               cmd_valid,
    output logic [DATA_W-1:0]  cmd_data,
    output logic [CODEC_W-1:0] cmd_codec,
    input  logic               cmd_ready
);

    typedef struct packed {
        fetch_state_e      st;
        logic [PTR_W-1:0]  rp;
        logic [DATA_W-1:0] data;
    } fetch_t;

    fetch_t f_q, f_d;

    logic launch;

    always_comb begin
        f_d    = f_q;
        launch = 1'b0;
        case (f_q.st)
            FS_IDLE: begin
                if (run && (f_q.rp != wp) && !rp_clr) begin
                    launch = 1'b1;
                    f_d.st = FS_READ;
                end
            end
            FS_READ: begin
                f_d.data = mem_rd_data;
                f_d.st   = FS_SEND;
            end
            FS_SEND: begin
                if (cmd_ready) begin
                    f_d.rp = f_q.rp + 1'b1;
                    f_d.st = FS_IDLE;
                end
            end
            default: f_d.st = FS_IDLE;
        endcase
        if (rp_clr) f_d.rp = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: FS_IDLE, rp: '0, data: '0};
        else        f_q <= f_d;
    end

    assign mem_rd_en   = launch;
    assign mem_rd_addr = f_q.rp + 1'b1;
    assign cmd_valid   = (f_q.st == FS_SEND);
    assign cmd_data    = f_q.data;
    assign cmd_codec   = f_q.data[DATA_W-1 -: CODEC_W];
    assign rp          = f_q.rp;
    assign busy        = (f_q.st != FS_IDLE);

    AST_NO_OVERTAKE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (rp != wp)); // R3

    AST_RUN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> run); // R6

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data))); // R4

    AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en); // R4

    AST_RP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rp_clr |=> (rp == '0)); // R11

    AST_RP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !rp_clr) |=> (rp == $past(rp) + 1'b1)); // R2

endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch
    import cmd_ring_pkg::*;
#(
    parameter int PTR_W   = 8,
    parameter int REG_W   = 16,
    parameter int DATA_W  = 32,
    parameter int CODEC_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_down,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               mem_rd_en,
    output logic [PTR_W-1:0]   mem_rd_addr,
    input  logic [DATA_W-1:0]  mem_rd_data,
    output logic               cmd_valid,
    output logic [DATA_W-1:0]  cmd_data,
    output logic [CODEC_W-1:0] cmd_codec,
    input  logic               cmd_ready
);

    logic [PTR_W-1:0] wp, rp;
    logic             run, rp_clr, busy;

    cmd_ring_regs #(.PTR_W(PTR_W), .REG_W(REG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_down  (pwr_down),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rp        (rp),
        .busy      (busy),
        .wp        (wp),
        .run       (run),
        .rp_clr    (rp_clr)
    );

    cmd_ring_fetcher #(.PTR_W(PTR_W), .DATA_W(DATA_W), .CODEC_W(CODEC_W)) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .wp          (wp),
        .rp_clr      (rp_clr),
        .rp          (rp),
        .busy        (busy),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .cmd_valid   (cmd_valid),
        .cmd_data    (cmd_data),
        .cmd_codec   (cmd_codec),
        .cmd_ready   (cmd_ready)
    );

endmodule

// File: tb/tb_cmd_ring_fetch.sv
`timescale 1ns/1ps
module tb_cmd_ring_fetch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_down = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        mem_rd_en;
    logic [7:0]  mem_rd_addr;
    logic [31:0] mem_rd_data = 32'd0;
    logic        cmd_valid;
    logic [31:0] cmd_data;
    logic [3:0]  cmd_codec;
    logic        cmd_ready = 1'b0;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [31:0] ring [256];
    logic [7:0]  wp_m = 8'd0;
    logic [7:0]  rp_m = 8'd0;

    always #10 clk = ~clk;

    cmd_ring_fetch dut (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_codec(cmd_codec), .cmd_ready(cmd_ready)
    );

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= ring[mem_rd_addr];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #2;
        v = reg_rdata;
    endtask

    task automatic push(input logic [31:0] w);
        wp_m = wp_m + 8'd1;
        ring[wp_m] = w;
        wr(2'd0, {8'd0, wp_m});
    endtask

    task automatic wait_valid(input string req);
        int n = 0;
        @(negedge clk);
        while (!cmd_valid && n < 60) begin
            @(negedge clk);
            n++;
        end
        check(req, {31'd0, cmd_valid}, 32'd1);
    endtask

    task automatic take(input string req, input int stall);
        logic [31:0] exp;
        rp_m = rp_m + 8'd1;
        exp = ring[rp_m];
        wait_valid(req);
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            check("R4 hold", {31'd0, cmd_valid}, 32'd1);
            check("R4 stable", cmd_data, exp);
        end
        check(req, cmd_data, exp);
        check("R5 codec", {28'd0, cmd_codec}, {28'd0, exp[31:28]});
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(2'd0, v); check("R1 wp", {16'd0, v}, 32'h0);
        rd(2'd1, v); check("R1 rp", {16'd0, v}, 32'h0);
        rd(2'd2, v); check("R1 ctl", {16'd0, v}, 32'h0);
        check("R1 valid", {31'd0, cmd_valid}, 32'd0);
    endtask

    task automatic t_regs();
        logic [15:0] v;
        wr(2'd0, 16'hFF12);
        rd(2'd0, v); check("R9 wp upper", {16'd0, v}, 32'h0012);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0055);
        rd(2'd1, v); check("R8 rp ignore", {16'd0, v}, 32'h0000);
        wr(2'd3, 16'h0002);
        rd(2'd3, v); check("R12 size", {16'd0, v}, 32'h0002);
        pwr_down = 1'b1;
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v); check("R10 pwrdn", {16'd0, v}, 32'hFFFF);
        end
        pwr_down = 1'b0;
    endtask

    task automatic t_basic();
        logic [15:0] v;
        push(32'hA1234567);
        push(32'h35550001);
        push(32'hF0000ABC);
        repeat (5) @(negedge clk);
        check("R6 no run", {31'd0, cmd_valid}, 32'd0);
        wr(2'd2, 16'h0002);
        take("R2 first", 0);
        take("R2 second", 3);
        take("R2 third", 1);
        repeat (6) @(negedge clk);
        check("R3 empty", {31'd0, cmd_valid}, 32'd0);
        rd(2'd1, v); check("R2 rp", {16'd0, v}, {24'd0, rp_m});
    endtask

    task automatic t_stop();
        logic [15:0] v;
        push(32'h71111111);
        push(32'h82222222);
        wait_valid("R6 inflight");
        wr(2'd2, 16'h0000);
        rd(2'd2, v); check("R6 busy readback", {16'd0, v}, 32'h0002);
        take("R6 drain", 0);
        rd(2'd2, v); check("R6 stopped", {16'd0, v}, 32'h0000);
        repeat (8) @(negedge clk);
        check("R6 no fetch", {31'd0, cmd_valid}, 32'd0);
        rd(2'd1, v); check("R6 rp", {16'd0, v}, {24'd0, rp_m});
        wr(2'd2, 16'h0002);
        take("R6 resume", 0);
    endtask

    task automatic t_full();
        logic [15:0] v;
        wr(2'd2, 16'h0000);
        for (int i = 0; i < 255; i++) push({i[3:0], 4'h5, i[23:0]});
        check("R3 full rule", {24'd0, wp_m + 8'd1}, {24'd0, rp_m});
        wr(2'd2, 16'h0002);
        for (int i = 0; i < 255; i++) take("R3 full drain", 0);
        repeat (8) @(negedge clk);
        check("R3 stop at wp", {31'd0, cmd_valid}, 32'd0);
        rd(2'd1, v); check("R3 rp==wp", {16'd0, v}, {24'd0, wp_m});
    endtask

    task automatic t_restart();
        logic [15:0] v;
        wr(2'd2, 16'h0000);
        wp_m = 8'd0;
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h8000);
        rd(2'd1, v); check("R7 set", {16'd0, v}, 32'h8000);
        wr(2'd1, 16'h0000);
        rd(2'd1, v); check("R7 clear", {16'd0, v}, 32'h0000);
        rp_m = 8'd0;
    endtask

    task automatic t_collide();
        logic [15:0] v;
        push(32'h9ABCDEF0);
        wr(2'd2, 16'h0002);
        wait_valid("R11 pending");
        @(negedge clk);
        cmd_ready = 1'b1;
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h8000;
        @(negedge clk);
        cmd_ready = 1'b0; reg_wr = 1'b0;
        rd(2'd1, v); check("R11 restart wins", {16'd0, v}, 32'h8000);
        wr(2'd1, 16'h0000);
        take("R11 refetch", 0);
    endtask

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_basic();
        t_stop();
        t_full();
        t_restart();
        t_collide();
        done = 1'b1;
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            finish_up();
        end
    end

endmodule